// File: doc/BRIEF.md
# Byte-Laned Asynchronous SRAM Emulator

This block is a synthesizable functional stand-in for a 16-bit-wide static RAM that has a classic asynchronous control interface. The control strobes are active low: a chip select, a write strobe, an output-enable strobe and one byte-lane enable per 8-bit lane. They are sampled on a system clock together with the address and the write data. The 16-bit bidirectional data bus is split into three parts: an input word, an output word and a per-lane drive-enable vector. An enclosing pad ring or a testbench can rebuild the tri-state bus from these. A lane that is not driving shows zero on its output bits.

The sampled strobes are decoded into one of four modes. Standby applies while the chip is deselected. Read, write and outputs-disabled apply while it is selected. A write does not take effect while its strobes are held. Each lane commits at the end of its own overlap of chip select, write strobe and lane enable, using the address and data seen in the last sampled cycle of that overlap. The storage depth is 2^ADDR_W words. A 15-bit address gives 32,768 words, and the default build uses a smaller depth.

Top module: `sram_emu`

## Requirements
- R1: Every address holds its own word. Words written to distinct addresses read back independently.
- R2: Lane 0 (bits 7:0, enable be_n_i[0]) is written only when its enable is low during the write overlap.
- R3: Lane 1 (bits 15:8, enable be_n_i[1]) is written only when its enable is low during the write overlap.
- R4: In read mode a lane drives (data_oe_o bit set, data_o bits carry the stored byte) only when its own enable is low. A lane that is not driving outputs zero.
- R5: While chip select is high, standby_o is 1, mode_o is 0 (standby), no lane drives and nothing is written, whatever the other inputs are.
- R6: Chip select low, write strobe low and at least one lane enable low give mode_o 2 (write) with no lane driving, even when output enable is low.
- R7: Chip select low, write strobe high and output enable high give mode_o 3 (outputs disabled), with standby_o 0 and no lane driving.
- R8: Chip select low with both lane enables high gives mode_o 3, no lane drives and no byte is written.
- R9: A lane commits when its overlap ends. If one lane enable rises before the others, that lane keeps the data it had in its last active cycle, and the other lane commits its later data when its own overlap ends.
- R10: After reset the block is in standby with no lane driving, and inputs have no effect during reset. Outputs reflect the inputs sampled at the previous clock edge. Mode encoding: 0 standby, 1 read, 2 write, 3 outputs disabled.
- R11: A lane that is not written keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Word address |
| ce_n_i | input | 1 | Chip select, active low |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| be_n_i | input | DATA_W/8 | Lane enables, active low, bit 0 = bits 7:0 |
| data_i | input | DATA_W | Write data from the bus |
| data_o | output | DATA_W | Read data toward the bus, zero on lanes not driving |
| data_oe_o | output | DATA_W/8 | Per-lane drive enable |
| standby_o | output | 1 | High while the chip is deselected |
| mode_o | output | 2 | Decoded mode: 0 standby, 1 read, 2 write, 3 off |

## Verification
Full-word writes and reads at the lowest, the highest and a middle address show that the words are independent. Single-lane writes followed by full reads show which lane was touched and which kept its contents. Reads with each lane-enable combination separate per-lane gating from whole-word gating. Conflicting strobe sets make write take precedence over output enable, standby take precedence over everything else, and both-lanes-off end in the disabled mode without any effect on storage. A staggered write, where one lane enable rises a cycle early, can only read back correctly if each lane commits at the end of its own overlap.

// File: rtl/sram_emu_pkg.sv
// Shared types for the SRAM emulator.
package sram_emu_pkg;
    // Decoded operating mode; encoding is visible on mode_o.
    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_READ    = 2'd1,
        MODE_WRITE   = 2'd2,
        MODE_OFF     = 2'd3
    } mode_e;
endpackage

// File: rtl/sram_emu_ctrl.sv
// Strobe decoder. Turns the sampled active-low strobes into a mode and
// per-lane write-overlap and read-drive flags.
// Assumes: inputs are already registered; purely combinational.
module sram_emu_ctrl
    import sram_emu_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] be_n,
    output mode_e            mode,
    output logic [LANES-1:0] wr_act,
    output logic [LANES-1:0] rd_drive
);
    logic any_lane;

    // Any lane enabled at all.
    assign any_lane = (be_n != {LANES{1'b1}});

    // Mode priority: deselect, then write strobe, then output enable.
    always_comb begin
        if (ce_n)                   mode = MODE_STANDBY;
        else if (!we_n && any_lane) mode = MODE_WRITE;
        else if (!we_n)             mode = MODE_OFF;
        else if (!oe_n && any_lane) mode = MODE_READ;
        else                        mode = MODE_OFF;
    end

    // Per-lane gating of both the write and the read path.
    for (genvar g = 0; g < LANES; g++) begin : g_lane_flags
        assign wr_act[g]   = !ce_n && !we_n && !be_n[g];
        assign rd_drive[g] = (mode == MODE_READ) && !be_n[g];
    end
endmodule

// File: rtl/sram_emu_lane.sv
// One 8-bit byte lane: storage array, end-of-overlap write tracker and
// gated read port.
// Assumes: address, data and lane enable come from the input stage;
// storage is not reset (contents undefined until written).
module sram_emu_lane #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [LANE_W-1:0] din_s,
    input  logic              be_n_s,
    input  logic              wr_act,
    input  logic              rd_drive,
    output logic [LANE_W-1:0] dout,
    output logic              drive_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] store [DEPTH];
    logic              act_q;
    logic [ADDR_W-1:0] hold_addr;
    logic [LANE_W-1:0] hold_data;
    logic              commit;

    // Remember whether this lane was inside a write overlap last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= wr_act;
    end

    // Track address and data of the latest active cycle of the overlap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr <= '0;
            hold_data <= '0;
        end else if (wr_act) begin
            hold_addr <= addr_s;
            hold_data <= din_s;
        end
    end

    // Overlap has just ended for this lane.
    assign commit = act_q && !wr_act;

    // Commit the held byte into storage at the end of the overlap.
    always_ff @(posedge clk) begin
        if (commit) store[hold_addr] <= hold_data;
    end

    // Read port: stored byte only when this lane drives, zero otherwise.
    assign drive_o = rd_drive;
    assign dout    = rd_drive ? store[addr_s] : '0;

    // A driving lane must have its own enable asserted.
    assert_drive_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |-> !be_n_s);
endmodule

// File: rtl/sram_emu.sv
// Top of the SRAM emulator. Registers the asynchronous-style pins on the
// system clock, decodes them, and fans out to one storage lane per byte.
// Assumes: DATA_W is a multiple of 8; outputs lag the pins by one clock.
module sram_emu
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                ce_n_i,
    input  logic                we_n_i,
    input  logic                oe_n_i,
    input  logic [DATA_W/8-1:0] be_n_i,
    input  logic [DATA_W-1:0]   data_i,
    output logic [DATA_W-1:0]   data_o,
    output logic [DATA_W/8-1:0] data_oe_o,
    output logic                standby_o,
    output logic [1:0]          mode_o
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = 8;

    logic [ADDR_W-1:0] addr_s;
    logic              ce_n_s;
    logic              we_n_s;
    logic              oe_n_s;
    logic [LANES-1:0]  be_n_s;
    logic [DATA_W-1:0] data_s;
    mode_e             mode;
    logic [LANES-1:0]  wr_act;
    logic [LANES-1:0]  rd_drive;

    // Input stage: sample pins; reset forces a deselected, idle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_s <= '0;
            ce_n_s <= 1'b1;
            we_n_s <= 1'b1;
            oe_n_s <= 1'b1;
            be_n_s <= {LANES{1'b1}};
            data_s <= '0;
        end else begin
            addr_s <= addr_i;
            ce_n_s <= ce_n_i;
            we_n_s <= we_n_i;
            oe_n_s <= oe_n_i;
            be_n_s <= be_n_i;
            data_s <= data_i;
        end
    end

    sram_emu_ctrl #(.LANES(LANES)) ctrl_i (
        .ce_n     (ce_n_s),
        .we_n     (we_n_s),
        .oe_n     (oe_n_s),
        .be_n     (be_n_s),
        .mode     (mode),
        .wr_act   (wr_act),
        .rd_drive (rd_drive)
    );

    // One storage lane per byte of the data word.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_emu_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .addr_s   (addr_s),
            .din_s    (data_s[g*LANE_W +: LANE_W]),
            .be_n_s   (be_n_s[g]),
            .wr_act   (wr_act[g]),
            .rd_drive (rd_drive[g]),
            .dout     (data_o[g*LANE_W +: LANE_W]),
            .drive_o  (data_oe_o[g])
        );
    end

    // Status outputs.
    assign standby_o = ce_n_s;
    assign mode_o    = mode;

    // Deselected chip neither drives nor reports any other mode.
    assert_standby_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> (data_oe_o == '0 && mode_o == MODE_STANDBY));

    // Write strobe overrides output enable: no lane drives during a write.
    assert_write_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_WRITE) |-> (data_oe_o == '0));

    // Deselect sampled at one edge shows up as standby after that edge.
    assert_ce_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ce_n_i)) |-> standby_o);

    // Read mode always has at least one driving lane.
    assert_read_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_READ) |-> (data_oe_o != '0));
endmodule

// File: tb/sram_emu_tb_top.sv
module sram_emu_tb_top;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          ce_n_i = 1'b1;
    logic          we_n_i = 1'b1;
    logic          oe_n_i = 1'b1;
    logic [1:0]    be_n_i = 2'b11;
    logic [15:0]   data_i = '0;
    logic [15:0]   data_o;
    logic [1:0]    data_oe_o;
    logic          standby_o;
    logic [1:0]    mode_o;

    sram_emu #(.ADDR_W(AW), .DATA_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_n_i(ce_n_i),
        .we_n_i(we_n_i), .oe_n_i(oe_n_i), .be_n_i(be_n_i), .data_i(data_i),
        .data_o(data_o), .data_oe_o(data_oe_o), .standby_o(standby_o),
        .mode_o(mode_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          due;
        logic [15:0] data;
        logic [1:0]  oe;
        logic [1:0]  mode;
        logic        stby;
        string       tag;
    } exp_t;

    exp_t        scb[$];
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    logic [15:0] shadow [1 << AW];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every expected item in the cycle it falls due.
    always @(negedge clk) begin
        while (scb.size() > 0 && scb[0].due <= cyc) begin
            exp_t e;
            e = scb.pop_front();
            checks++;
            if (data_o !== e.data || data_oe_o !== e.oe ||
                mode_o !== e.mode || standby_o !== e.stby) begin
                errors++;
                $display("FAIL %s: got data=%h oe=%b mode=%0d stby=%b, exp data=%h oe=%b mode=%0d stby=%b",
                         e.tag, data_o, data_oe_o, mode_o, standby_o,
                         e.data, e.oe, e.mode, e.stby);
            end
        end
    end

    // Driver: apply one cycle of pins and queue the expected outputs.
    task automatic apply(input logic ce, input logic we, input logic oe,
                         input logic [1:0] be, input logic [AW-1:0] a,
                         input logic [15:0] d, input logic [15:0] xd,
                         input logic [1:0] xoe, input logic [1:0] xm,
                         input logic xs, input string tag);
        exp_t e;
        @(negedge clk);
        ce_n_i = ce; we_n_i = we; oe_n_i = oe; be_n_i = be;
        addr_i = a; data_i = d;
        e.due = cyc + 1; e.data = xd; e.oe = xoe; e.mode = xm;
        e.stby = xs; e.tag = tag;
        scb.push_back(e);
    endtask

    task automatic idle(input string tag);
        apply(1, 1, 1, 2'b11, '0, '0, '0, 2'b00, 2'd0, 1'b1, tag);
    endtask

    // Write with output enable held low (R6: write must win).
    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d,
                      input logic [1:0] be, input string tag);
        logic [1:0] m;
        m = (be == 2'b11) ? 2'd3 : 2'd2;
        apply(0, 0, 0, be, a, d, '0, 2'b00, m, 1'b0, tag);
        idle(tag);
        idle(tag);
        if (!be[0]) shadow[a][7:0]  = d[7:0];
        if (!be[1]) shadow[a][15:8] = d[15:8];
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [1:0] be,
                      input string tag);
        logic [15:0] x;
        logic [1:0]  m;
        x = '0;
        if (!be[0]) x[7:0]  = shadow[a][7:0];
        if (!be[1]) x[15:8] = shadow[a][15:8];
        m = (be == 2'b11) ? 2'd3 : 2'd1;
        apply(0, 1, 0, be, a, 16'hDEAD, x, ~be, m, 1'b0, tag);
    endtask

    initial begin
        // R10: inputs ignored during reset, standby afterwards.
        apply(0, 0, 0, 2'b00, 10'd5, 16'hFFFF, '0, 2'b00, 2'd0, 1'b1, "R10 in reset");
        apply(0, 1, 0, 2'b00, 10'd5, 16'hFFFF, '0, 2'b00, 2'd0, 1'b1, "R10 in reset");
        @(negedge clk); rst_n = 1'b1;
        idle("R10 after reset");

        // R1: distinct addresses; R6 checked on each write cycle.
        wr(10'd0,    16'h1234, 2'b00, "R1 R6 write low addr");
        wr(10'd1023, 16'hA5C3, 2'b00, "R1 R6 write high addr");
        wr(10'h155,  16'h0F0F, 2'b00, "R1 R6 write mid addr");
        wr(10'd1,    16'h7788, 2'b00, "R1 write addr 1");
        rd(10'd0,    2'b00, "R1 read low addr");
        rd(10'd1023, 2'b00, "R1 read high addr");
        rd(10'h155,  2'b00, "R1 read mid addr");

        // R2/R11: lower lane only; upper keeps old byte.
        wr(10'd0, 16'hEEBB, 2'b10, "R2 lower-only write");
        rd(10'd0, 2'b00, "R2 R11 read after lower-only");
        // R3/R11: upper lane only.
        wr(10'd1023, 16'h66EE, 2'b01, "R3 upper-only write");
        rd(10'd1023, 2'b00, "R3 R11 read after upper-only");

        // R4: per-lane read gating.
        rd(10'd1, 2'b01, "R4 read upper lane only");
        rd(10'd1, 2'b10, "R4 read lower lane only");

        // R8: both lanes off, write and read.
        wr(10'd1, 16'h0000, 2'b11, "R8 write no lanes");
        rd(10'd1, 2'b11, "R8 read no lanes");
        rd(10'd1, 2'b00, "R8 contents unchanged");

        // R5: deselected with write strobes: standby and no store.
        apply(1, 0, 0, 2'b00, 10'd1, 16'h9999, '0, 2'b00, 2'd0, 1'b1, "R5 ce high with write");
        apply(1, 1, 0, 2'b00, 10'd1, 16'h9999, '0, 2'b00, 2'd0, 1'b1, "R5 ce high with read");
        idle("R5 idle");
        rd(10'd1, 2'b00, "R5 nothing written while deselected");

        // R7: output enable high, selected, no write.
        apply(0, 1, 1, 2'b00, 10'd1, '0, '0, 2'b00, 2'd3, 1'b0, "R7 outputs disabled");

        // R9: staggered write; upper lane ends one cycle early.
        apply(0, 0, 0, 2'b00, 10'h155, 16'h1122, '0, 2'b00, 2'd2, 1'b0, "R9 both lanes");
        apply(0, 0, 0, 2'b10, 10'h155, 16'h3344, '0, 2'b00, 2'd2, 1'b0, "R9 lower lane only");
        idle("R9 end");
        idle("R9 end");
        shadow[10'h155] = 16'h1144;
        rd(10'h155, 2'b00, "R9 staggered result");

        idle("final");
        idle("final");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule